// File: doc/BRIEF.md
# Linked Descriptor Queue DMA Engine

This block is the queue engine of one endpoint. It walks a chain of 16-byte descriptors in memory. Each descriptor is four 32-bit words: a flag word, the next-descriptor pointer, the buffer pointer and a length word. The engine reads all four words and then decides what to do. It handles every descriptor whose ownership bit is set. On each completed descriptor it writes the transferred length back and hands the descriptor back to software by clearing the ownership bit. It then follows the next pointer.

It stops and waits at the first descriptor it does not own. Software fills in more descriptors and then issues a resume command, which makes the engine read its current descriptor again. The USB packet path is reduced to a beat stream, one beat per data unit, so the engine counts beats down against the length. A side signal marks a trailing zero-length packet.

Two length layouts are selectable: a 16-bit legacy layout and a 20-bit extended layout. Addresses are 36 bits wide. The upper 4 bits of each address come from a nibble field inside the descriptor.

Top module: `ldq_dma_engine`

## Requirements
- R1: A start pulse loads the current address from `start_addr_i`, raises `active_o` on the next clock and begins fetching. A stop pulse has priority over start. It clears `active_o` on the next clock. After it there are no more memory requests and no more stream beats, and a descriptor stopped in mid-transfer gets no writeback.
- R2: When the ownership bit (word 0 bit 0) of the current descriptor is clear, the engine parks. It keeps `cur_addr_o`, writes nothing and does not read that descriptor again until a resume pulse arrives. The resume pulse makes it read the four words at the same address again.
- R3: An owned descriptor with the bypass flag (word 0 bit 2) set produces no beats, gets no writeback and raises no interrupt. The engine moves straight to the next pointer.
- R4: On transmit (`dir_tx_i`=1), the transfer length is word 3 bits [15:0] in legacy mode (`ext_mode_i`=0) and word 3 bits [19:0] in extended mode. The engine emits one `str_beat_o` in each cycle that `str_ready_i` is high, until that many beats are done.
- R5: On receive, the transfer length is the smaller of `rx_len_i` and the allowed buffer length. The allowed buffer length is word 0 bits [31:16] in legacy mode and word 0 bits [31:12] in extended mode.
- R6: On completion the engine writes word 3 first. The length field ([15:0] legacy, [19:0] extended) is replaced by the transferred length, and all other bits are kept. Next it writes word 0 with bit 0 cleared and all other bits kept. Only after that does the current address become the next pointer.
- R7: The 4-bit upper address nibbles sit at bits [23:20] for the next pointer and [19:16] for the buffer in legacy mode. In extended mode they sit at [31:28] and [27:24]. For transmit they are taken from word 0 and for receive from word 3. The next address is {next nibble, word 1}, and `buf_addr_o` is {buffer nibble, word 2}. Descriptors are 16-byte aligned.
- R8: A transmit zero-length flag produces exactly one `str_zlp_o` pulse after the data beats and before the writeback. The flag is word 3 bit 29 in legacy mode and word 0 bit 6 in extended mode.
- R9: In legacy mode, a transmit descriptor with length zero is not transferred. It raises `len_err_o` and parks on that descriptor with no writeback. The flag clears on resume, start or stop. In extended mode a zero-length transmit descriptor completes normally.
- R10: `done_irq_o` is sticky. It is set when a descriptor with interrupt-on-completion (word 0 bit 7) completes, and it is cleared by `done_clr_i`. A completion in the same cycle as a clear wins over the clear.
- R11: After reset, `active_o`, `done_irq_o` and `len_err_o` are 0, `cur_addr_o` is 0, and no memory request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_mode_i | input | 1 | 1 selects the extended 20-bit length layout |
| dir_tx_i | input | 1 | 1 for transmit, 0 for receive |
| start_addr_i | input | 36 | First descriptor address |
| cmd_start_i | input | 1 | Start pulse |
| cmd_stop_i | input | 1 | Stop pulse |
| cmd_resume_i | input | 1 | Resume pulse |
| done_clr_i | input | 1 | Write-1 clear of the done interrupt |
| active_o | output | 1 | Queue active |
| cur_addr_o | output | 36 | Current descriptor address |
| len_err_o | output | 1 | Legacy zero-length transmit error |
| done_irq_o | output | 1 | Sticky done interrupt |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for a write access |
| mem_addr_o | output | 36 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after a read request |
| rx_len_i | input | 20 | Receive length offered by the stream side |
| str_ready_i | input | 1 | Stream accepts a beat this cycle |
| str_beat_o | output | 1 | One data beat moved |
| str_zlp_o | output | 1 | Zero-length packet marker |
| buf_addr_o | output | 36 | Buffer address of the current descriptor |

## Verification
If the length field or mode decode is wrong, the error shows in the beat count within a few cycles of the fetch. It also shows in the word 3 value written back at completion, so a wrong bit mask is visible in memory as soon as the descriptor completes. If the ownership, bypass or stop handling is wrong, the engine writes to a descriptor it should leave alone or advances past it. This shows as a changed word 0 or a moved `cur_addr_o` once the chain settles. A wrong nibble position shows at once in `cur_addr_o` and `buf_addr_o`, because both expose the upper four bits.

// File: rtl/ldq_pkg.sv
package ldq_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned LEN_EXT_W   = 20;
  localparam int unsigned LEN_LEG_W   = 16;
  localparam int unsigned F_OWN       = 0;
  localparam int unsigned F_BYP       = 2;
  localparam int unsigned F_ZLP_EXT   = 6;
  localparam int unsigned F_IOC       = 7;
  localparam int unsigned F_ZLP_LEG   = 29;
  localparam int unsigned NXT_LEG_LSB = 20;
  localparam int unsigned BUF_LEG_LSB = 16;
  localparam int unsigned NXT_EXT_LSB = 28;
  localparam int unsigned BUF_EXT_LSB = 24;

  typedef enum logic [3:0] {
    S_IDLE, S_F0, S_F1, S_F2, S_F3, S_F4, S_EVAL,
    S_XFER, S_ZLP, S_WB3, S_WB0, S_ADV, S_PARK
  } ldq_state_e;
endpackage

// File: rtl/ldq_desc_decode.sv
module ldq_desc_decode
  import ldq_pkg::*;
#(
  parameter int unsigned HI_W = 4
) (
  input  logic                 ext_i,
  input  logic                 tx_i,
  input  logic [WORD_W-1:0]    w0_i,
  input  logic [WORD_W-1:0]    w3_i,
  input  logic [LEN_EXT_W-1:0] act_i,
  output logic                 own_o,
  output logic                 byp_o,
  output logic                 ioc_o,
  output logic                 zlp_o,
  output logic [LEN_EXT_W-1:0] data_len_o,
  output logic [LEN_EXT_W-1:0] buf_len_o,
  output logic [HI_W-1:0]      next_hi_o,
  output logic [HI_W-1:0]      buf_hi_o,
  output logic [WORD_W-1:0]    w3_wb_o
);
  logic [WORD_W-1:0] hi_src;

  // transmit keeps the address nibbles in the flag word, receive in the length word
  assign hi_src = tx_i ? w0_i : w3_i;

  assign own_o = w0_i[F_OWN];
  assign byp_o = w0_i[F_BYP];
  assign ioc_o = w0_i[F_IOC];
  assign zlp_o = tx_i & (ext_i ? w0_i[F_ZLP_EXT] : w3_i[F_ZLP_LEG]);

  assign next_hi_o = ext_i ? hi_src[NXT_EXT_LSB +: HI_W] : hi_src[NXT_LEG_LSB +: HI_W];
  assign buf_hi_o  = ext_i ? hi_src[BUF_EXT_LSB +: HI_W] : hi_src[BUF_LEG_LSB +: HI_W];

  assign data_len_o = ext_i ? w3_i[LEN_EXT_W-1:0]
                            : LEN_EXT_W'(w3_i[LEN_LEG_W-1:0]);
  assign buf_len_o  = ext_i ? w0_i[WORD_W-1 -: LEN_EXT_W]
                            : LEN_EXT_W'(w0_i[WORD_W-1 -: LEN_LEG_W]);

  assign w3_wb_o = ext_i ? {w3_i[WORD_W-1:LEN_EXT_W], act_i}
                         : {w3_i[WORD_W-1:LEN_LEG_W], act_i[LEN_LEG_W-1:0]};
endmodule

// File: rtl/ldq_beat_ctr.sv
module ldq_beat_ctr #(
  parameter int unsigned LEN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             run_i,
  input  logic             ready_i,
  output logic             beat_o,
  output logic             empty_o
);
  logic [LEN_W-1:0] rem_q;

  assign empty_o = (rem_q == '0);
  assign beat_o  = run_i & ready_i & ~empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rem_q <= '0;
    else if (load_i)  rem_q <= len_i;
    else if (beat_o)  rem_q <= rem_q - 1'b1;
  end
endmodule

// File: rtl/ldq_dma_engine.sv
module ldq_dma_engine
  import ldq_pkg::*;
#(
  parameter int unsigned HI_W  = 4,
  parameter int unsigned LEN_W = LEN_EXT_W,
  localparam int unsigned AW   = WORD_W + HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_mode_i,
  input  logic              dir_tx_i,
  input  logic [AW-1:0]     start_addr_i,
  input  logic              cmd_start_i,
  input  logic              cmd_stop_i,
  input  logic              cmd_resume_i,
  input  logic              done_clr_i,
  output logic              active_o,
  output logic [AW-1:0]     cur_addr_o,
  output logic              len_err_o,
  output logic              done_irq_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic [LEN_W-1:0]  rx_len_i,
  input  logic              str_ready_i,
  output logic              str_beat_o,
  output logic              str_zlp_o,
  output logic [AW-1:0]     buf_addr_o
);
  ldq_state_e state_q, state_d;
  logic [AW-1:0]     cur_q;
  logic [WORD_W-1:0] w0_q, w1_q, w2_q, w3_q;
  logic [LEN_W-1:0]  act_q;
  logic              active_q, err_q, irq_q;

  logic              own, byp, ioc, zlp;
  logic [LEN_W-1:0]  data_len, buf_len, rx_eff, xfer_len;
  logic [HI_W-1:0]   next_hi, buf_hi;
  logic [WORD_W-1:0] w3_wb;
  logic              ctr_empty, ctr_load, lz_err;

  ldq_desc_decode #(.HI_W(HI_W)) u_dec (
    .ext_i      (ext_mode_i),
    .tx_i       (dir_tx_i),
    .w0_i       (w0_q),
    .w3_i       (w3_q),
    .act_i      (act_q),
    .own_o      (own),
    .byp_o      (byp),
    .ioc_o      (ioc),
    .zlp_o      (zlp),
    .data_len_o (data_len),
    .buf_len_o  (buf_len),
    .next_hi_o  (next_hi),
    .buf_hi_o   (buf_hi),
    .w3_wb_o    (w3_wb)
  );

  assign rx_eff   = (rx_len_i < buf_len) ? rx_len_i : buf_len;
  assign xfer_len = dir_tx_i ? data_len : rx_eff;
  assign ctr_load = (state_q == S_EVAL);
  assign lz_err   = dir_tx_i & ~ext_mode_i & (data_len == '0);

  ldq_beat_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (ctr_load),
    .len_i   (xfer_len),
    .run_i   (state_q == S_XFER),
    .ready_i (str_ready_i),
    .beat_o  (str_beat_o),
    .empty_o (ctr_empty)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_F0:   state_d = S_F1;
      S_F1:   state_d = S_F2;
      S_F2:   state_d = S_F3;
      S_F3:   state_d = S_F4;
      S_F4:   state_d = S_EVAL;
      S_EVAL: begin
        if (!own)        state_d = S_PARK;
        else if (byp)    state_d = S_ADV;
        else if (lz_err) state_d = S_PARK;
        else             state_d = S_XFER;
      end
      S_XFER: if (ctr_empty) state_d = zlp ? S_ZLP : S_WB3;
      S_ZLP:  state_d = S_WB3;
      S_WB3:  state_d = S_WB0;
      S_WB0:  state_d = S_ADV;
      S_ADV:  state_d = S_F0;
      S_PARK: if (cmd_resume_i) state_d = S_F0;
      default: ;
    endcase
    if (cmd_stop_i)       state_d = S_IDLE;
    else if (cmd_start_i) state_d = S_F0;
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_q;
    mem_wdata_o = '0;
    unique case (state_q)
      S_F0: mem_req_o = 1'b1;
      S_F1: begin mem_req_o = 1'b1; mem_addr_o = cur_q + AW'(4);  end
      S_F2: begin mem_req_o = 1'b1; mem_addr_o = cur_q + AW'(8);  end
      S_F3: begin mem_req_o = 1'b1; mem_addr_o = cur_q + AW'(12); end
      S_WB3: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_q + AW'(12);
        mem_wdata_o = w3_wb;
      end
      S_WB0: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = w0_q & ~(WORD_W'(1) << F_OWN);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      cur_q    <= '0;
      w0_q     <= '0;
      w1_q     <= '0;
      w2_q     <= '0;
      w3_q     <= '0;
      act_q    <= '0;
      active_q <= 1'b0;
      err_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_F1) w0_q <= mem_rdata_i;
      if (state_q == S_F2) w1_q <= mem_rdata_i;
      if (state_q == S_F3) w2_q <= mem_rdata_i;
      if (state_q == S_F4) w3_q <= mem_rdata_i;
      if (state_q == S_EVAL) act_q <= xfer_len;

      if (cmd_stop_i)       active_q <= 1'b0;
      else if (cmd_start_i) active_q <= 1'b1;

      if (!cmd_stop_i && cmd_start_i)          cur_q <= start_addr_i;
      else if (!cmd_stop_i && state_q == S_ADV) cur_q <= {next_hi, w1_q};

      if (cmd_stop_i || cmd_start_i)                 err_q <= 1'b0;
      else if (state_q == S_PARK && cmd_resume_i)    err_q <= 1'b0;
      else if (state_q == S_EVAL && own && !byp && lz_err) err_q <= 1'b1;

      // a completion in the clear cycle keeps the flag set
      if (state_q == S_ADV && ioc && !byp && !cmd_stop_i) irq_q <= 1'b1;
      else if (done_clr_i)                                irq_q <= 1'b0;
    end
  end

  assign active_o   = active_q;
  assign cur_addr_o = cur_q;
  assign len_err_o  = err_q;
  assign done_irq_o = irq_q;
  assign str_zlp_o  = (state_q == S_ZLP);
  assign buf_addr_o = {buf_hi, w2_q};

  // beats seen since the last evaluation, for the length check below
  logic [LEN_W-1:0] beat_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 beat_seen_q <= '0;
    else if (state_q == S_EVAL)  beat_seen_q <= '0;
    else if (str_beat_o)         beat_seen_q <= beat_seen_q + 1'b1;
  end

  AST_START_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_start_i && !cmd_stop_i) |=> (active_o && cur_addr_o == $past(start_addr_i))); // R1
  AST_STOP_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stop_i |=> (!active_o && !mem_req_o && !str_beat_o)); // R1
  AST_PARK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PARK && !cmd_resume_i && !cmd_start_i) |=> ($stable(cur_q) && !mem_req_o)); // R2
  AST_CUR_ONLY_ON_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_start_i && state_q != S_ADV) |=> $stable(cur_q)); // R6
  AST_ADV_AFTER_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ADV) |-> ($past(state_q) == S_WB0 || $past(state_q) == S_EVAL)); // R6
  AST_BEATS_MATCH_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WB3) |-> (beat_seen_q == act_q)); // R4
  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_irq_o) |-> $past(state_q == S_ADV)); // R10
endmodule

// File: tb/tb_ldq_dma_engine.sv
`timescale 1ns/1ps
module tb_ldq_dma_engine;
  localparam int unsigned AW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic ext_mode = 1'b0, dir_tx = 1'b1;
  logic [AW-1:0] start_addr = '0;
  logic cmd_start = 1'b0, cmd_stop = 1'b0, cmd_resume = 1'b0, done_clr = 1'b0;
  logic active, len_err, done_irq, mem_req, mem_we, str_beat, str_zlp;
  logic [AW-1:0] cur_addr, mem_addr, buf_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [19:0] rx_len = '0;
  logic str_ready = 1'b1;

  ldq_dma_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_mode_i(ext_mode), .dir_tx_i(dir_tx),
    .start_addr_i(start_addr), .cmd_start_i(cmd_start), .cmd_stop_i(cmd_stop),
    .cmd_resume_i(cmd_resume), .done_clr_i(done_clr), .active_o(active),
    .cur_addr_o(cur_addr), .len_err_o(len_err), .done_irq_o(done_irq),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .rx_len_i(rx_len),
    .str_ready_i(str_ready), .str_beat_o(str_beat), .str_zlp_o(str_zlp),
    .buf_addr_o(buf_addr)
  );

  logic [31:0] mem [64];
  logic        tb_we = 1'b0;
  logic [5:0]  tb_widx = '0;
  logic [31:0] tb_wdata = '0;
  logic        cnt_clr = 1'b0;
  int          beats, zlps;

  always @(posedge clk) begin
    if (tb_we) mem[tb_widx] <= tb_wdata;
    else if (mem_req && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:2]];
    if (cnt_clr) begin
      beats <= 0;
      zlps  <= 0;
    end else begin
      if (str_beat) beats <= beats + 1;
      if (str_zlp)  zlps  <= zlps + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk); tb_we = 1'b1; tb_widx = 6'(idx); tb_wdata = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  task automatic do_start(input logic [AW-1:0] a);
    @(negedge clk); start_addr = a; cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
  endtask
  task automatic do_stop();
    @(negedge clk); cmd_stop = 1'b1;
    @(negedge clk); cmd_stop = 1'b0;
  endtask
  task automatic do_resume();
    @(negedge clk); cmd_resume = 1'b1;
    @(negedge clk); cmd_resume = 1'b0;
  endtask
  task automatic do_clear();
    @(negedge clk); done_clr = 1'b1; cnt_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0; cnt_clr = 1'b0;
  endtask

  typedef struct packed {
    logic        ext;
    logic        tx;
    logic [31:0] w0;
    logic [31:0] w3;
    logic [19:0] rxl;
    logic [31:0] ew0;
    logic [31:0] ew3;
    logic [35:0] ecur;
    logic [7:0]  ebeats;
    logic        ezlp;
    logic        eirq;
    logic        eerr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 32'h0000_0081, 32'h0000_0005, 20'd0,  32'h0000_0080, 32'h0000_0005, 36'h40, 8'd5, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b1, 32'h0000_0001, 32'h0001_0004, 20'd0,  32'h0000_0000, 32'h0001_0004, 36'h40, 8'd4, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 32'h0000_0081, 32'h1230_0006, 20'd0,  32'h0000_0080, 32'h1230_0006, 36'h40, 8'd6, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b0, 32'h0008_0081, 32'h0000_0000, 20'd5,  32'h0008_0080, 32'h0000_0005, 36'h40, 8'd5, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b0, 32'h0008_0001, 32'h0000_0000, 20'd12, 32'h0008_0000, 32'h0000_0008, 36'h40, 8'd8, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 32'h0000_A001, 32'h00F0_0000, 20'd7,  32'h0000_A000, 32'h00F0_0007, 36'h40, 8'd7, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 32'h0000_0085, 32'h0000_0009, 20'd0,  32'h0000_0085, 32'h0000_0009, 36'h40, 8'd0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 32'h0000_00C1, 32'h0000_0000, 20'd0,  32'h0000_00C0, 32'h0000_0000, 36'h40, 8'd0, 1'b1, 1'b1, 1'b0},
    '{1'b0, 1'b1, 32'h0000_0081, 32'h2000_0002, 20'd0,  32'h0000_0080, 32'h2000_0002, 36'h40, 8'd2, 1'b1, 1'b1, 1'b0},
    '{1'b0, 1'b1, 32'h0000_0080, 32'h0000_0003, 20'd0,  32'h0000_0080, 32'h0000_0003, 36'h00, 8'd0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 32'h0000_0081, 32'h0000_0000, 20'd0,  32'h0000_0081, 32'h0000_0000, 36'h00, 8'd0, 1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b1, 32'h0000_0081, 32'h0000_0000, 20'd0,  32'h0000_0080, 32'h0000_0000, 36'h40, 8'd0, 1'b0, 1'b1, 1'b0}
  };
  localparam string VTAG [NV] = '{"R4", "R4", "R4", "R5", "R5", "R5", "R3", "R8", "R8", "R2", "R9", "R9"};

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem_rdata = '0;
    beats = 0;
    zlps = 0;
    repeat (3) @(negedge clk);
    chk("R11", "mem_req in reset", 64'(mem_req), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "active after reset", 64'(active), 64'd0);
    chk("R11", "cur_addr after reset", 64'(cur_addr), 64'd0);
    chk("R11", "irq after reset", 64'(done_irq), 64'd0);
    chk("R11", "len_err after reset", 64'(len_err), 64'd0);

    for (int i = 0; i < NV; i++) begin
      do_stop();
      wr(0, VEC[i].w0); wr(1, 32'h40); wr(2, 32'h100); wr(3, VEC[i].w3);
      wr(16, 32'h0); wr(17, 32'h80); wr(18, 32'h0); wr(19, 32'h0);
      ext_mode = VEC[i].ext; dir_tx = VEC[i].tx; rx_len = VEC[i].rxl; str_ready = 1'b1;
      do_clear();
      do_start(36'h0);
      repeat (80) @(negedge clk);
      chk(VTAG[i], $sformatf("vec%0d word0", i), 64'(mem[0]), 64'(VEC[i].ew0));
      chk(VTAG[i], $sformatf("vec%0d word3", i), 64'(mem[3]), 64'(VEC[i].ew3));
      chk(VTAG[i], $sformatf("vec%0d cur_addr", i), 64'(cur_addr), 64'(VEC[i].ecur));
      chk(VTAG[i], $sformatf("vec%0d beats", i), 64'(beats), 64'(VEC[i].ebeats));
      chk("R8", $sformatf("vec%0d zlp pulses", i), 64'(zlps), 64'(VEC[i].ezlp));
      chk("R10", $sformatf("vec%0d irq", i), 64'(done_irq), 64'(VEC[i].eirq));
      chk("R9", $sformatf("vec%0d len_err", i), 64'(len_err), 64'(VEC[i].eerr));
      chk("R1", $sformatf("vec%0d active", i), 64'(active), 64'd1);
    end

    // R10: write-1 clear of the sticky flag
    do_clear();
    chk("R10", "irq after clear", 64'(done_irq), 64'd0);

    // R7: extended transmit next pointer with upper nibble 1
    do_stop();
    ext_mode = 1'b1; dir_tx = 1'b1;
    wr(0, 32'h1000_0081); wr(1, 32'h40); wr(2, 32'h0); wr(3, 32'h1); wr(16, 32'h0);
    do_clear();
    do_start(36'h0);
    repeat (40) @(negedge clk);
    chk("R7", "next addr upper nibble", 64'(cur_addr), 64'h1_0000_0040);

    // R2: park, no polling, resume re-reads the same descriptor
    do_stop();
    ext_mode = 1'b0; dir_tx = 1'b1;
    wr(0, 32'h81); wr(1, 32'h40); wr(2, 32'h0); wr(3, 32'h1);
    wr(16, 32'h0); wr(17, 32'h80); wr(19, 32'h0); wr(32, 32'h0);
    do_clear();
    do_start(36'h0);
    repeat (40) @(negedge clk);
    chk("R2", "parked at unowned", 64'(cur_addr), 64'h40);
    wr(16, 32'h81); wr(19, 32'h2);
    repeat (30) @(negedge clk);
    chk("R2", "no advance without resume", 64'(cur_addr), 64'h40);
    chk("R2", "no beats without resume", 64'(beats), 64'd1);
    do_resume();
    repeat (40) @(negedge clk);
    chk("R2", "advanced after resume", 64'(cur_addr), 64'h80);
    chk("R6", "resumed word3 writeback", 64'(mem[19]), 64'h2);
    chk("R6", "resumed word0 writeback", 64'(mem[16]), 64'h80);
    chk("R4", "beats after resume", 64'(beats), 64'd3);

    // R9: error clears on resume after software sets bypass
    do_stop();
    wr(0, 32'h81); wr(1, 32'h40); wr(3, 32'h0); wr(16, 32'h0);
    do_start(36'h0);
    repeat (40) @(negedge clk);
    chk("R9", "legacy zero length error", 64'(len_err), 64'd1);
    chk("R9", "error parks in place", 64'(cur_addr), 64'h0);
    wr(0, 32'h85);
    do_resume();
    repeat (40) @(negedge clk);
    chk("R9", "error cleared by resume", 64'(len_err), 64'd0);
    chk("R3", "bypassed after resume", 64'(cur_addr), 64'h40);

    // R1: stall then stop in mid-transfer
    do_stop();
    str_ready = 1'b0; ext_mode = 1'b1; dir_tx = 1'b1;
    wr(0, 32'h0300_0081); wr(1, 32'h40); wr(2, 32'h100); wr(3, 32'd30);
    do_clear();
    do_start(36'h0);
    repeat (30) @(negedge clk);
    chk("R4", "no beats while not ready", 64'(beats), 64'd0);
    chk("R7", "buffer addr nibble", 64'(buf_addr), 64'h3_0000_0100);
    chk("R1", "active before stop", 64'(active), 64'd1);
    do_stop();
    chk("R1", "active after stop", 64'(active), 64'd0);
    chk("R1", "no request after stop", 64'(mem_req), 64'd0);
    str_ready = 1'b1;
    repeat (50) @(negedge clk);
    chk("R1", "no beats after stop", 64'(beats), 64'd0);
    chk("R1", "no writeback after stop", 64'(mem[0]), 64'h0300_0081);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule